// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by reading a two-level table of 32-bit entries from memory. A request carries the address, the kind of access (instruction fetch, data load or data store), the current privilege, whether paged translation is on, the root table page number and four status controls: supervisor access to user pages, make-executable-readable, modify-privilege and the saved previous privilege. When the walk ends, the block raises a one-cycle completion strobe together with a fault flag, the physical address and the read, write and execute rights that apply to the page.

Each entry holds a 22-bit page number in bits 31:10 and flags in bits 7:0: valid (bit 0), readable (bit 1), writable (bit 2), executable (bit 3), user (bit 4), global (bit 5), accessed (bit 6) and dirty (bit 7). Leaves go through the full set of checks: reserved flag combinations, privilege, superpage alignment and access rights. On success the block sets the accessed flag, and on a store the dirty flag as well, and writes the entry back before it completes. The memory port is a held request with a one-cycle acknowledge, and the read data is taken in the acknowledge cycle.

Access codes are 0 fetch, 1 load, 2 store. Privilege codes are 0 user, 1 supervisor, 3 machine.

Top module: `ptw_top`

## Requirements
- R1: The effective privilege is the previous-privilege input when the current privilege is machine, modify-privilege is set and the access is a load or a store. A fetch always uses the current privilege.
- R2: When the effective privilege is machine or paging is off, the result carries no fault, equals the virtual address zero-extended and has read, write and execute all set, and no memory access is made.
- R3: The first entry is read at root*4096 + va[31:22]*4. A pointer entry leads to a second read at its page number*4096 + va[21:12]*4. The memory address is word-aligned and held steady until it is acknowledged.
- R4: An entry with the valid flag clear faults. A pointer entry (valid set, readable, writable and executable all clear) met at the second level faults.
- R5: Leaves that are writable but not readable (with or without executable) are reserved and fault.
- R6: A user page faults when the effective privilege is not user and either supervisor-access-to-user is clear or the access is a fetch. A page without the user flag faults when the effective privilege is not supervisor.
- R7: A leaf at the first level whose page number has any of its low 10 bits set faults.
- R8: A load needs readable, or executable with make-executable-readable set. A store needs writable. A fetch needs executable.
- R9: On a successful walk the entry with accessed set, and with dirty set for a store, is written back to the same address before completion, only when this changes the entry. Faulting walks write nothing.
- R10: A second-level leaf gives {ppn, va[11:0]}. A first-level leaf gives {ppn[21:10], va[21:0]}.
- R11: The read right is readable or (executable and make-executable-readable). Execute is the executable flag. Write is writable and (store or dirty already set). On a fault all rights are zero.
- R12: Completion is a single-cycle strobe. A request is taken only while idle, and requests presented during a walk are ignored. After reset the block is idle with no strobe and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request, taken while idle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_paged | input | 1 | Paged translation enabled |
| req_root_ppn | input | 22 | Root table page number |
| req_sum | input | 1 | Supervisor may touch user pages |
| req_mxr | input | 1 | Executable pages readable by loads |
| req_mprv | input | 1 | Loads and stores use previous privilege in machine mode |
| req_mpp | input | 2 | Previous privilege |
| idle | output | 1 | Walker can take a request |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 34 | Byte address of the entry |
| mem_wdata | output | 32 | Entry write-back data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Entry read data, valid with acknowledge |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Walk failed |
| paddr | output | 34 | Physical address |
| perm_r | output | 1 | Read right |
| perm_w | output | 1 | Write right |
| perm_x | output | 1 | Execute right |

## Verification
Directed walks set up single table entries so that each fault rule fires on its own. Examples are a user page seen from supervisor with and without the user-access control, an execute-only page loaded with and without the readable-executable control, reserved writable leaves, and misaligned versus aligned superpages. This separates the checks from one another. Paired load and store walks on one entry separate the accessed-only write-back from the dirty write-back, and the dirty-dependent write right. A second pair on an entry that already has both flags shows that no write is made. Machine-mode requests with modify-privilege, taken as fetch and as load, separate the bypass from a real walk by the number of memory reads. Random addresses, flags, privileges and controls over random two-level tables are then compared with a bench model for the fault, the address, the rights and the written entry.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    parameter int OFF_W  = 12;
    parameter int IDX_W  = 10;
    parameter int PPN_W  = 22;
    parameter int FLAG_W = 10;
    parameter int PTE_W  = PPN_W + FLAG_W;
    parameter int VA_W   = OFF_W + 2 * IDX_W;
    parameter int PA_W   = PPN_W + OFF_W;
    parameter int ENT_SH = 2;

    parameter int B_V = 0;
    parameter int B_R = 1;
    parameter int B_W = 2;
    parameter int B_X = 3;
    parameter int B_U = 4;
    parameter int B_A = 6;
    parameter int B_D = 7;

    parameter logic [1:0] MODE_U = 2'd0;
    parameter logic [1:0] MODE_S = 2'd1;
    parameter logic [1:0] MODE_M = 2'd3;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } wst_e;

    typedef struct packed {
        wst_e              st;
        logic              top_lvl;
        logic [VA_W-1:0]   va;
        acc_e              acc;
        logic [1:0]        mode;
        logic              sum;
        logic              mxr;
        logic [PA_W-1:0]   ent_addr;
        logic [PTE_W-1:0]  wdata;
        logic              flt;
        logic [PA_W-1:0]   pa;
        logic              pr;
        logic              pw;
        logic              px;
    } wregs_t;
endpackage

// File: rtl/ptw_mode_sel.sv
module ptw_mode_sel
    import ptw_pkg::*;
(
    input  logic [1:0] priv,
    input  acc_e       acc,
    input  logic       mprv,
    input  logic [1:0] mpp,
    input  logic       paged,
    output logic [1:0] eff_mode,
    output logic       bypass
);
    always_comb begin
        eff_mode = priv;
        if (priv == MODE_M && acc != ACC_FETCH && mprv) begin
            eff_mode = mpp;
        end
        bypass = (eff_mode == MODE_M) || !paged;
    end
endmodule

// File: rtl/ptw_leaf_chk.sv
module ptw_leaf_chk
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0]       pte,
    input  logic                   top_lvl,
    input  logic [IDX_W+OFF_W-1:0] va_lo,
    input  acc_e                   acc,
    input  logic [1:0]             mode,
    input  logic                   sum,
    input  logic                   mxr,
    output logic                   is_ptr,
    output logic                   leaf_flt,
    output logic [PTE_W-1:0]       pte_upd,
    output logic [PA_W-1:0]        leaf_pa,
    output logic                   pr,
    output logic                   pw,
    output logic                   px
);
    logic [PPN_W-1:0] ppn;
    logic rsvd, user_bad, sup_bad, misal, rd_ok, acc_bad;

    assign ppn = pte[PTE_W-1:FLAG_W];

    always_comb begin
        is_ptr   = pte[B_V] & ~pte[B_R] & ~pte[B_W] & ~pte[B_X];
        rsvd     = pte[B_W] & ~pte[B_R];
        user_bad = pte[B_U] & (mode != MODE_U) & (~sum | (acc == ACC_FETCH));
        sup_bad  = ~pte[B_U] & (mode != MODE_S);
        misal    = top_lvl & (ppn[IDX_W-1:0] != '0);
        rd_ok    = pte[B_R] | (pte[B_X] & mxr);
        acc_bad  = ((acc == ACC_LOAD)  & ~rd_ok)
                 | ((acc == ACC_STORE) & ~pte[B_W])
                 | ((acc == ACC_FETCH) & ~pte[B_X]);
        leaf_flt = ~pte[B_V] | rsvd | user_bad | sup_bad | misal | acc_bad;

        pte_upd      = pte;
        pte_upd[B_A] = 1'b1;
        if (acc == ACC_STORE) begin
            pte_upd[B_D] = 1'b1;
        end

        if (top_lvl) begin
            leaf_pa = {ppn[PPN_W-1:IDX_W], va_lo};
        end else begin
            leaf_pa = {ppn, va_lo[OFF_W-1:0]};
        end

        pr = rd_ok;
        px = pte[B_X];
        pw = pte[B_W] & ((acc == ACC_STORE) | pte[B_D]);
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [1:0]        req_priv,
    input  logic              req_paged,
    input  logic [PPN_W-1:0]  req_root_ppn,
    input  logic              req_sum,
    input  logic              req_mxr,
    input  logic              req_mprv,
    input  logic [1:0]        req_mpp,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [PTE_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [PTE_W-1:0]  mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [PA_W-1:0]   paddr,
    output logic              perm_r,
    output logic              perm_w,
    output logic              perm_x
);
    localparam int VPN1_LO = OFF_W + IDX_W;

    wregs_t q, d;

    logic [1:0]       eff_mode;
    logic             bypass;
    logic             is_ptr, leaf_flt, l_pr, l_pw, l_px;
    logic [PTE_W-1:0] pte_upd;
    logic [PA_W-1:0]  leaf_pa;

    ptw_mode_sel u_mode (
        .priv     (req_priv),
        .acc      (acc_e'(req_acc)),
        .mprv     (req_mprv),
        .mpp      (req_mpp),
        .paged    (req_paged),
        .eff_mode (eff_mode),
        .bypass   (bypass)
    );

    ptw_leaf_chk u_leaf (
        .pte      (mem_rdata),
        .top_lvl  (q.top_lvl),
        .va_lo    (q.va[VPN1_LO-1:0]),
        .acc      (q.acc),
        .mode     (q.mode),
        .sum      (q.sum),
        .mxr      (q.mxr),
        .is_ptr   (is_ptr),
        .leaf_flt (leaf_flt),
        .pte_upd  (pte_upd),
        .leaf_pa  (leaf_pa),
        .pr       (l_pr),
        .pw       (l_pw),
        .px       (l_px)
    );

    function automatic logic [PA_W-1:0] ent_at(input logic [PPN_W-1:0] ppn,
                                               input logic [IDX_W-1:0] idx);
        return {ppn, {OFF_W{1'b0}}} + PA_W'({idx, {ENT_SH{1'b0}}});
    endfunction

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va   = req_vaddr;
                    d.acc  = acc_e'(req_acc);
                    d.mode = eff_mode;
                    d.sum  = req_sum;
                    d.mxr  = req_mxr;
                    d.flt  = 1'b0;
                    if (bypass) begin
                        d.pa = PA_W'(req_vaddr);
                        d.pr = 1'b1;
                        d.pw = 1'b1;
                        d.px = 1'b1;
                        d.st = ST_RESP;
                    end else begin
                        d.pa       = '0;
                        d.pr       = 1'b0;
                        d.pw       = 1'b0;
                        d.px       = 1'b0;
                        d.top_lvl  = 1'b1;
                        d.ent_addr = ent_at(req_root_ppn, req_vaddr[VA_W-1:VPN1_LO]);
                        d.st       = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    if (!mem_rdata[B_V]) begin
                        d.flt = 1'b1;
                        d.st  = ST_RESP;
                    end else if (is_ptr) begin
                        if (q.top_lvl) begin
                            d.top_lvl  = 1'b0;
                            d.ent_addr = ent_at(mem_rdata[PTE_W-1:FLAG_W],
                                                q.va[VPN1_LO-1:OFF_W]);
                        end else begin
                            d.flt = 1'b1;
                            d.st  = ST_RESP;
                        end
                    end else if (leaf_flt) begin
                        d.flt = 1'b1;
                        d.st  = ST_RESP;
                    end else begin
                        d.pa = leaf_pa;
                        d.pr = l_pr;
                        d.pw = l_pw;
                        d.px = l_px;
                        if (pte_upd != mem_rdata) begin
                            d.wdata = pte_upd;
                            d.st    = ST_WRITE;
                        end else begin
                            d.st = ST_RESP;
                        end
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign idle      = (q.st == ST_IDLE);
    assign mem_req   = (q.st == ST_READ) || (q.st == ST_WRITE);
    assign mem_we    = (q.st == ST_WRITE);
    assign mem_addr  = q.ent_addr;
    assign mem_wdata = q.wdata;
    assign done      = (q.st == ST_RESP);
    assign fault     = q.flt;
    assign paddr     = q.pa;
    assign perm_r    = q.pr;
    assign perm_w    = q.pw;
    assign perm_x    = q.px;
endmodule

// File: rtl/ptw_top_chk.sv
module ptw_top_chk
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             idle,
    input logic             mem_req,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic [PTE_W-1:0] mem_wdata,
    input logic             mem_ack,
    input logic             done,
    input logic             fault,
    input logic             perm_r,
    input logic             perm_w,
    input logic             perm_x
);
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mem_req && !done));

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_addr_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ENT_SH-1:0] == '0));

    assert_wb_accessed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[B_A] && mem_wdata[B_V]));

    assert_fault_noperm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (!perm_r && !perm_w && !perm_x));

    assert_write_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && perm_w) |-> perm_r);
endmodule

bind ptw_top ptw_top_chk u_ptw_top_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (idle),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .done      (done),
    .fault     (fault),
    .perm_r    (perm_r),
    .perm_w    (perm_w),
    .perm_x    (perm_x)
);

// File: tb/test_ptw_top.sv
`timescale 1ns/1ps
module test_ptw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_priv = '0;
    logic        req_paged = 1'b0;
    logic [21:0] req_root_ppn = 22'd1;
    logic        req_sum = 1'b0;
    logic        req_mxr = 1'b0;
    logic        req_mprv = 1'b0;
    logic [1:0]  req_mpp = '0;
    logic        idle, mem_req, mem_we, done, fault, perm_r, perm_w, perm_x;
    logic [33:0] mem_addr, paddr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:4095];
    int rd_cnt = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    ptw_top i_ptw_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_priv(req_priv), .req_paged(req_paged),
        .req_root_ppn(req_root_ppn), .req_sum(req_sum), .req_mxr(req_mxr),
        .req_mprv(req_mprv), .req_mpp(req_mpp), .idle(idle), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .paddr(paddr), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
    );

    always @(posedge clk) begin
        if (done) done_cnt++;
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata <= mem[mem_addr[13:2]];
                rd_cnt++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    function automatic logic [31:0] mk(input logic [21:0] ppn, input logic [7:0] fl);
        return {ppn, 2'b00, fl};
    endfunction

    function automatic void ref_walk(
        input  logic [31:0] va, input logic [1:0] acc, input logic [1:0] priv,
        input  logic paged, input logic [21:0] root, input logic sum,
        input  logic mxr, input logic mprv, input logic [1:0] mpp,
        output logic f, output logic [33:0] pa, output logic [2:0] rwx,
        output logic thru, output logic wb, output logic [11:0] wb_idx,
        output logic [31:0] wb_val);
        logic [1:0]  m;
        logic [33:0] a;
        logic [31:0] p, np;
        logic        lv;
        f = 1'b1; pa = '0; rwx = '0; thru = 1'b0; wb = 1'b0; wb_idx = '0; wb_val = '0;
        m = (priv == 2'd3 && acc != 2'd0 && mprv) ? mpp : priv;
        if (m == 2'd3 || !paged) begin
            f = 1'b0; pa = {2'b00, va}; rwx = 3'b111; thru = 1'b1;
            return;
        end
        a  = {root, 12'h000} + {22'd0, va[31:22], 2'b00};
        lv = 1'b1;
        for (int i = 0; i < 2; i++) begin
            p = mem[a[13:2]];
            if (!p[0]) return;
            if (p[3:1] == 3'b000) begin
                if (!lv) return;
                a  = {p[31:10], 12'h000} + {22'd0, va[21:12], 2'b00};
                lv = 1'b0;
                continue;
            end
            if (p[2] && !p[1]) return;
            if (p[4] && m != 2'd0 && (!sum || acc == 2'd0)) return;
            if (!p[4] && m != 2'd1) return;
            if (lv && p[19:10] != 10'd0) return;
            if (acc == 2'd1 && !(p[1] || (p[3] && mxr))) return;
            if (acc == 2'd2 && !p[2]) return;
            if (acc == 2'd0 && !p[3]) return;
            np = p | 32'h40 | ((acc == 2'd2) ? 32'h80 : 32'h0);
            if (np != p) begin wb = 1'b1; wb_idx = a[13:2]; wb_val = np; end
            f  = 1'b0;
            pa = lv ? {p[31:20], va[21:0]} : {p[31:10], va[11:0]};
            rwx = {p[1] | (p[3] & mxr), p[2] & ((acc == 2'd2) | p[7]), p[3]};
            return;
        end
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input string tag, input logic [31:0] va, input logic [1:0] acc,
                          input logic [1:0] priv, input logic paged, input logic sum,
                          input logic mxr, input logic mprv, input logic [1:0] mpp);
        logic e_f, e_thru, e_wb;
        logic [33:0] e_pa;
        logic [2:0] e_rwx;
        logic [11:0] e_idx;
        logic [31:0] e_val;
        int n;
        ref_walk(va, acc, priv, paged, req_root_ppn, sum, mxr, mprv, mpp,
                 e_f, e_pa, e_rwx, e_thru, e_wb, e_idx, e_val);
        @(negedge clk);
        req_vaddr = va; req_acc = acc; req_priv = priv; req_paged = paged;
        req_sum = sum; req_mxr = mxr; req_mprv = mprv; req_mpp = mpp;
        rd_cnt = 0; wr_cnt = 0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " done seen"}, 64'(done), 64'd1);
        chk({tag, " fault"}, 64'(fault), 64'(e_f));
        chk({tag, " paddr"}, 64'(paddr), 64'(e_pa));
        chk({tag, " rights rwx"}, 64'({perm_r, perm_w, perm_x}), 64'(e_rwx));
        chk({tag, " writes"}, 64'(wr_cnt), 64'(e_wb));
        if (e_wb) chk({tag, " written entry"}, 64'(mem[e_idx]), 64'(e_val));
        if (e_thru) chk({tag, " no reads"}, 64'(rd_cnt), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        tests++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] va, rp, lp;
        logic [11:0] li;
        int d0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) mem[i] = '0;

        repeat (3) @(negedge clk);
        chk("R12 reset idle", 64'(idle), 64'd1);
        chk("R12 reset done", 64'(done), 64'd0);
        chk("R12 reset mem_req", 64'(mem_req), 64'd0);
        rst_n = 1'b1;

        // root table at page 1 (index 1024), second level at page 2 (index 2048)
        mem[1024 + 1] = mk(22'd2, 8'h01);
        mem[2048 + 1] = mk(22'h12345, 8'h07);           // S page R W, no A/D
        mem[2048 + 2] = mk(22'h0ABCD, 8'hC7);           // S page R W A D
        mem[2048 + 3] = mk(22'h00777, 8'h19);           // U page X only
        mem[2048 + 4] = mk(22'h00555, 8'h13);           // U page R
        mem[2048 + 5] = mk(22'h00666, 8'h43);           // S page R A only
        mem[1024 + 2] = mk({12'hABC, 10'h000}, 8'h5B);  // U superpage R X A
        mem[1024 + 3] = mk({12'hABC, 10'h004}, 8'h5B);  // misaligned superpage
        mem[1024 + 4] = 32'h0;                          // invalid
        mem[1024 + 5] = mk(22'd3, 8'h01);
        mem[3072 + 0] = mk(22'd2, 8'h01);               // pointer at second level
        mem[1024 + 6] = mk(22'h00100, 8'h05);           // W only
        mem[1024 + 7] = mk(22'h00100, 8'h0D);           // W X

        do_req("R2 machine load", 32'h0040_1234, 2'd1, 2'd3, 1'b1, 0, 0, 0, 2'd0);
        do_req("R2 bare supervisor store", 32'hDEAD_BEEF, 2'd2, 2'd1, 1'b0, 0, 0, 0, 2'd0);
        do_req("R1 mprv load walks as S", 32'h0040_2FFC, 2'd1, 2'd3, 1'b1, 0, 0, 1, 2'd1);
        do_req("R1 mprv fetch bypass", 32'h0040_2FFC, 2'd0, 2'd3, 1'b1, 0, 0, 1, 2'd1);
        do_req("R9 load sets accessed R11", 32'h0040_1234, 2'd1, 2'd1, 1'b1, 0, 0, 0, 2'd0);
        do_req("R9 store sets dirty R11", 32'h0040_1234, 2'd2, 2'd1, 1'b1, 0, 0, 0, 2'd0);
        do_req("R9 no writeback when set", 32'h0040_2010, 2'd2, 2'd1, 1'b1, 0, 0, 0, 2'd0);
        do_req("R11 load on clean page", 32'h0040_5010, 2'd1, 2'd1, 1'b1, 0, 0, 0, 2'd0);
        do_req("R10 superpage fetch user", 32'h0089_ABCD, 2'd0, 2'd0, 1'b1, 0, 0, 0, 2'd0);
        do_req("R7 misaligned superpage", 32'h00C0_0000, 2'd1, 2'd0, 1'b1, 0, 0, 0, 2'd0);
        do_req("R4 invalid entry", 32'h0100_0000, 2'd1, 2'd1, 1'b1, 0, 0, 0, 2'd0);
        do_req("R4 pointer at leaf level", 32'h0140_0000, 2'd1, 2'd1, 1'b1, 0, 0, 0, 2'd0);
        do_req("R5 write only leaf", 32'h0180_0000, 2'd2, 2'd1, 1'b1, 0, 0, 0, 2'd0);
        do_req("R5 write exec leaf", 32'h01C0_0000, 2'd2, 2'd1, 1'b1, 0, 0, 0, 2'd0);
        do_req("R6 user page S no sum", 32'h0040_4000, 2'd1, 2'd1, 1'b1, 0, 0, 0, 2'd0);
        do_req("R6 user page S with sum", 32'h0040_4000, 2'd1, 2'd1, 1'b1, 1, 0, 0, 2'd0);
        do_req("R6 user page S sum fetch", 32'h0040_3000, 2'd0, 2'd1, 1'b1, 1, 0, 0, 2'd0);
        do_req("R6 super page from U", 32'h0040_2000, 2'd1, 2'd0, 1'b1, 0, 0, 0, 2'd0);
        do_req("R8 exec only load no mxr", 32'h0040_3004, 2'd1, 2'd0, 1'b1, 0, 0, 0, 2'd0);
        do_req("R8 exec only load mxr", 32'h0040_3004, 2'd1, 2'd0, 1'b1, 0, 1, 0, 2'd0);
        do_req("R8 store on read only", 32'h0040_4008, 2'd2, 2'd0, 1'b1, 0, 0, 0, 2'd0);
        do_req("R3 root page moves", 32'h0040_1000, 2'd1, 2'd1, 1'b1, 0, 0, 0, 2'd0);

        // R12: request presented while busy is ignored
        @(negedge clk);
        req_vaddr = 32'h0040_1238; req_acc = 2'd1; req_priv = 2'd1; req_paged = 1'b1;
        req_sum = 0; req_mxr = 0; req_mprv = 0; req_valid = 1'b1;
        done_cnt = 0; rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        req_vaddr = 32'h0000_0000; req_priv = 2'd3;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        repeat (15) @(negedge clk);
        chk("R12 one completion", 64'(done_cnt), 64'd1);
        chk("R12 walk result kept", 64'(paddr), 64'h1_2345_238);
        chk("R12 idle after", 64'(idle), 64'd1);

        for (int k = 0; k < 300; k++) begin
            va = $urandom;
            rp = $urandom;
            d0 = $urandom % 4;
            if (d0 < 2) rp = mk(22'(2 + ($urandom % 2)), 8'h01);
            else if (d0 == 2) rp[19:10] = 10'd0;
            if ($urandom % 4 != 0) rp[0] = 1'b1;
            mem[1024 + int'(va[31:22])] = rp;
            li = 12'({rp[31:10], 10'd0} + {22'd0, va[21:12]});
            lp = $urandom;
            if ($urandom % 4 != 0) lp[0] = 1'b1;
            if ($urandom % 2 == 0) lp[31:10] = 22'd0;
            mem[li] = lp;
            do_req("R8 R6 random walk", va, 2'($urandom % 3), 2'($urandom % 4),
                   1'($urandom % 8 != 0), 1'($urandom), 1'($urandom),
                   1'($urandom), 2'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule